// File: doc/BRIEF.md
# Double-Buffered Serial DAC Code Register with Power Control

This block is the digital side of an 8-bit converter pair. It takes a serial bit stream qualified by an active-low select and a per-bit strobe. It decodes control words from that stream, keeps the enable settings that decide which sections are powered, and holds DAC input data in two stages. The first stage is a holding byte that any complete data byte writes. The second stage is the code latch that drives the resistor ladder.

A data byte can be loaded while the DAC is shut down. It reaches the ladder when a later control word turns the DAC on. In continuous mode each full data byte goes straight to the latch with no control word between bytes. Dropping the select ends that mode. When the DAC is switched on, a timer raises a ready flag once a set number of clock cycles has passed.

Top module: `codec_dac_reg`

## Requirements
- R1: After reset, `dac_code` is 0, `pwr_state` is 0 (full shutdown), and `dac_on`, `dac_ready` and `cont_mode` are all 0.
- R2: While no word is open, strobed 0 bits are ignored. The first strobed 1 opens an 8-bit control word, sent MSB first and counting that 1 as bit 7. Bit 6 addresses the DAC. Bit 5 addresses the ADC and bit 4 selects the ADC input; neither has an effect here. Bit 3 selects continuous mode. Bits 2, 1 and 0 enable the reference, the ADC and the DAC.
- R3: The enable bits take effect when the eighth control bit is strobed, whatever the address bits hold. `pwr_state` encodes them {ref,adc,dac} as follows: 000 gives 0 (off), 100 gives 1 (standby), 110 gives 2 (ADC only), 101 gives 3 (DAC only), 111 gives 4 (both), and any other pattern gives 5. `dac_on` equals the DAC enable bit.
- R4: After a control word with bit 6 set, the next DATA_W strobed bits form a data byte, MSB first. If the DAC is enabled, `dac_code` takes that byte in the cycle after the edge that samples its last bit.
- R5: If the DAC is disabled, a data byte is held and `dac_code` does not change. A later control word that turns the DAC on copies the held byte to `dac_code`.
- R6: In single mode (bit 3 = 0), only one data byte follows a control word. Further 0 bits are ignored and leave `dac_code` unchanged.
- R7: In continuous mode, every further DATA_W strobed bits form a new data byte that updates `dac_code`, with no control word between bytes.
- R8: While `cs_n` is high, strobes are ignored and `dac_code` holds. `cont_mode` clears, and data after `cs_n` returns low needs a new control word.
- R9: If `cs_n` goes high before a data byte is complete, the partial byte is discarded. `dac_code` and the enables are unchanged.
- R10: If `cs_n` goes high after a control word has opened but before it completes, all enables clear (full shutdown). `dac_code` is kept.
- R11: `dac_ready` rises exactly WAKE_CYCLES cycles after the edge that turns the DAC on. It is 0 while the DAC is off. Writing the enable again while the DAC is already on does not restart the timer.
- R12: `cont_mode` shows bit 3 of the last completed control word. The ADC and the DAC share this one mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on state) |
| cs_n | input | 1 | Active-low select; high aborts or ignores the stream |
| bit_stb | input | 1 | One-cycle strobe marking a valid serial bit |
| bit_in | input | 1 | Serial data bit |
| dac_code | output | DATA_W | Code driving the ladder |
| dac_on | output | 1 | DAC enable state |
| dac_ready | output | 1 | DAC wake-up delay elapsed |
| pwr_state | output | 3 | Decoded power state |
| cont_mode | output | 1 | Shared continuous conversion mode |

## Verification
The bench builds the block with DATA_W = 8 and WAKE_CYCLES = 12. The short wake-up window lets a run see the ready flag expire, see it stay high when the DAC is enabled again, and see it restart after a shutdown, all within a few dozen cycles. With 8-bit data, both the control words and the data bytes hit the byte boundary of the shift counter. The run covers enabling the DAC before loading a byte, loading a byte before enabling the DAC, streaming several bytes in continuous mode, and aborting in the middle of a data byte and in the middle of a control word.

// File: rtl/codec_dac_pkg.sv
package codec_dac_pkg;

    localparam int CTRL_W = 8;

    typedef enum logic [2:0] {
        PWR_OFF     = 3'd0,
        PWR_STANDBY = 3'd1,
        PWR_ADC     = 3'd2,
        PWR_DAC     = 3'd3,
        PWR_BOTH    = 3'd4,
        PWR_NOREF   = 3'd5
    } pwr_state_t;

    typedef enum logic [1:0] {
        RX_HUNT = 2'd0,
        RX_CTRL = 2'd1,
        RX_DATA = 2'd2
    } rx_state_t;

    typedef struct packed {
        logic start;
        logic dac_sel;
        logic adc_sel;
        logic in_sel;
        logic cont;
        logic ref_en;
        logic adc_en;
        logic dac_en;
    } ctrl_word_t;

    typedef struct packed {
        logic ref_on;
        logic adc_on;
        logic dac_on;
    } enables_t;

    function automatic pwr_state_t pwr_decode(input enables_t e);
        pwr_state_t s;
        case ({e.ref_on, e.adc_on, e.dac_on})
            3'b000:  s = PWR_OFF;
            3'b100:  s = PWR_STANDBY;
            3'b110:  s = PWR_ADC;
            3'b101:  s = PWR_DAC;
            3'b111:  s = PWR_BOTH;
            default: s = PWR_NOREF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cdr_serial_rx.sv
module cdr_serial_rx
    import codec_dac_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              bit_stb,
    input  logic              bit_in,
    input  logic              cont_mode,
    output logic              ctrl_done,
    output logic [CTRL_W-1:0] ctrl_byte,
    output logic              ctrl_abort,
    output logic              data_done,
    output logic [DATA_W-1:0] data_byte
);
    localparam int SR_W  = (DATA_W > CTRL_W) ? DATA_W : CTRL_W;
    localparam int CNT_W = $clog2(SR_W + 1);

    rx_state_t         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [SR_W-1:0]   sreg_q;
    logic [SR_W-1:0]   shifted;
    logic              take;
    logic              unused_msb;

    assign take       = !cs_n && bit_stb;
    assign shifted    = {sreg_q[SR_W-2:0], bit_in};
    assign unused_msb = sreg_q[SR_W-1];

    assign ctrl_done  = take && (state_q == RX_CTRL) && (cnt_q == CNT_W'(CTRL_W - 1));
    assign ctrl_byte  = shifted[CTRL_W-1:0];
    assign data_done  = take && (state_q == RX_DATA) && (cnt_q == CNT_W'(DATA_W - 1));
    assign data_byte  = shifted[DATA_W-1:0];
    assign ctrl_abort = cs_n && (state_q == RX_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_HUNT;
            cnt_q   <= '0;
            sreg_q  <= '0;
        end else if (cs_n) begin
            state_q <= RX_HUNT;
            cnt_q   <= '0;
        end else if (take) begin
            sreg_q <= shifted;
            case (state_q)
                RX_HUNT: begin
                    if (bit_in) begin
                        state_q <= RX_CTRL;
                        cnt_q   <= CNT_W'(1);
                    end
                end
                RX_CTRL: begin
                    if (ctrl_done) begin
                        state_q <= ctrl_byte[6] ? RX_DATA : RX_HUNT;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                RX_DATA: begin
                    if (data_done) begin
                        state_q <= cont_mode ? RX_DATA : RX_HUNT;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    state_q <= RX_HUNT;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/cdr_pwr_ctrl.sv
module cdr_pwr_ctrl
    import codec_dac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              ctrl_done,
    input  logic [CTRL_W-1:0] ctrl_byte,
    input  logic              ctrl_abort,
    output logic              dac_en,
    output logic              dac_rise,
    output logic              cont_mode,
    output logic [2:0]        pwr_state
);
    ctrl_word_t cw;
    enables_t   en_q;
    logic       cont_q;
    logic       apply;
    logic       unused_fields;

    assign cw            = ctrl_word_t'(ctrl_byte);
    assign apply         = ctrl_done && cw.start;
    assign unused_fields = ^{cw.dac_sel, cw.adc_sel, cw.in_sel};

    assign dac_rise  = apply && cw.dac_en && !en_q.dac_on;
    assign dac_en    = en_q.dac_on;
    assign cont_mode = cont_q;
    assign pwr_state = pwr_decode(en_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            cont_q <= 1'b0;
        end else if (cs_n) begin
            cont_q <= 1'b0;
            if (ctrl_abort) begin
                en_q <= '0;
            end
        end else if (apply) begin
            en_q.ref_on <= cw.ref_en;
            en_q.adc_on <= cw.adc_en;
            en_q.dac_on <= cw.dac_en;
            cont_q      <= cw.cont;
        end
    end

endmodule

// File: rtl/cdr_wake_timer.sv
module cdr_wake_timer #(
    parameter int WAKE_CYCLES = 1250
) (
    input  logic clk,
    input  logic rst,
    input  logic dac_en,
    input  logic dac_rise,
    output logic ready
);
    localparam int WK_W = $clog2(WAKE_CYCLES + 1);

    logic [WK_W-1:0] cnt_q;

    assign ready = dac_en && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (dac_rise) begin
            cnt_q <= WK_W'(WAKE_CYCLES);
        end else if (!dac_en) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - WK_W'(1);
        end
    end

endmodule

// File: rtl/cdr_dac_latch.sv
module cdr_dac_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              data_done,
    input  logic [DATA_W-1:0] data_byte,
    input  logic              dac_en,
    input  logic              dac_rise,
    output logic [DATA_W-1:0] code
);
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] code_q;

    assign code = code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            code_q <= '0;
        end else begin
            if (data_done) begin
                hold_q <= data_byte;
                if (dac_en) begin
                    code_q <= data_byte;
                end
            end else if (dac_rise) begin
                code_q <= hold_q;
            end
        end
    end

endmodule

// File: rtl/codec_dac_reg.sv
module codec_dac_reg
    import codec_dac_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int WAKE_CYCLES = 1250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              bit_stb,
    input  logic              bit_in,
    output logic [DATA_W-1:0] dac_code,
    output logic              dac_on,
    output logic              dac_ready,
    output logic [2:0]        pwr_state,
    output logic              cont_mode
);
    logic              ctrl_done;
    logic [CTRL_W-1:0] ctrl_byte;
    logic              ctrl_abort;
    logic              data_done;
    logic [DATA_W-1:0] data_byte;
    logic              dac_en;
    logic              dac_rise;

    cdr_serial_rx #(.DATA_W(DATA_W)) rx_i (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .bit_stb    (bit_stb),
        .bit_in     (bit_in),
        .cont_mode  (cont_mode),
        .ctrl_done  (ctrl_done),
        .ctrl_byte  (ctrl_byte),
        .ctrl_abort (ctrl_abort),
        .data_done  (data_done),
        .data_byte  (data_byte)
    );

    cdr_pwr_ctrl pwr_i (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .ctrl_done  (ctrl_done),
        .ctrl_byte  (ctrl_byte),
        .ctrl_abort (ctrl_abort),
        .dac_en     (dac_en),
        .dac_rise   (dac_rise),
        .cont_mode  (cont_mode),
        .pwr_state  (pwr_state)
    );

    cdr_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) wake_i (
        .clk      (clk),
        .rst      (rst),
        .dac_en   (dac_en),
        .dac_rise (dac_rise),
        .ready    (dac_ready)
    );

    cdr_dac_latch #(.DATA_W(DATA_W)) latch_i (
        .clk       (clk),
        .rst       (rst),
        .data_done (data_done),
        .data_byte (data_byte),
        .dac_en    (dac_en),
        .dac_rise  (dac_rise),
        .code      (dac_code)
    );

    assign dac_on = dac_en;

endmodule

// File: rtl/codec_dac_reg_chk.sv
module codec_dac_reg_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic [DATA_W-1:0] dac_code,
    input logic              dac_on,
    input logic              dac_ready,
    input logic [2:0]        pwr_state,
    input logic              cont_mode
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dac_code == '0 && pwr_state == 3'd0 && !dac_on && !cont_mode));

    assert_state_legal_R3: assert property (@(posedge clk) disable iff (rst)
        pwr_state <= 3'd5);

    assert_code_holds_R8: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> $stable(dac_code));

    assert_mode_clears_R8: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !cont_mode);

    assert_no_enable_R10: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !$rose(dac_on));

    assert_off_not_ready_R11: assert property (@(posedge clk) disable iff (rst)
        !dac_on |-> !dac_ready);

    assert_wake_starts_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_on) |-> !dac_ready);

endmodule

bind codec_dac_reg codec_dac_reg_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .dac_code  (dac_code),
    .dac_on    (dac_on),
    .dac_ready (dac_ready),
    .pwr_state (pwr_state),
    .cont_mode (cont_mode)
);

// File: tb/codec_dac_reg_tb_top.sv
module codec_dac_reg_tb_top;
    localparam int DW = 8;
    localparam int WK = 12;

    logic          clk;
    logic          rst;
    logic          cs_n;
    logic          bit_stb;
    logic          bit_in;
    logic [DW-1:0] dac_code;
    logic          dac_on;
    logic          dac_ready;
    logic [2:0]    pwr_state;
    logic          cont_mode;

    int total;
    int bad;
    bit done;

    codec_dac_reg #(.DATA_W(DW), .WAKE_CYCLES(WK)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .bit_stb   (bit_stb),
        .bit_in    (bit_in),
        .dac_code  (dac_code),
        .dac_on    (dac_on),
        .dac_ready (dac_ready),
        .pwr_state (pwr_state),
        .cont_mode (cont_mode)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // behavioural reference model
    int         m_code;
    int         m_hold;
    int         m_wait;
    logic [2:0] m_en;
    bit         m_cont;
    int         m_phase;
    bit         m_bits[$];

    function automatic int pack_bits(input bit q[$]);
        int v;
        v = 0;
        foreach (q[i]) v = v * 2 + int'(q[i]);
        return v;
    endfunction

    function automatic int exp_pwr(input logic [2:0] e);
        if (e == 3'b000) return 0;
        if (e == 3'b100) return 1;
        if (e == 3'b110) return 2;
        if (e == 3'b101) return 3;
        if (e == 3'b111) return 4;
        return 5;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_code = 0; m_hold = 0; m_wait = 0; m_en = 3'b000;
            m_cont = 0; m_phase = 0; m_bits.delete();
        end else begin
            if (!m_en[0]) m_wait = 0;
            else if (m_wait > 0) m_wait = m_wait - 1;
            if (cs_n) begin
                if (m_phase == 1) m_en = 3'b000;
                m_phase = 0;
                m_cont = 0;
                m_bits.delete();
            end else if (bit_stb) begin
                m_bits.push_back(bit_in);
                if (m_phase == 0) begin
                    if (bit_in) m_phase = 1;
                    else m_bits.delete();
                end else if (m_phase == 1 && m_bits.size() == 8) begin
                    logic [7:0] cv;
                    cv = 8'(pack_bits(m_bits));
                    m_bits.delete();
                    if (cv[0] && !m_en[0]) begin
                        m_code = m_hold;
                        m_wait = WK;
                    end
                    m_en = cv[2:0];
                    m_cont = cv[3];
                    m_phase = cv[6] ? 2 : 0;
                end else if (m_phase == 2 && m_bits.size() == DW) begin
                    m_hold = pack_bits(m_bits);
                    m_bits.delete();
                    if (m_en[0]) m_code = m_hold;
                    m_phase = m_cont ? 2 : 0;
                end
            end
        end
    end

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R4 dac_code vs model", int'(dac_code), m_code);
            check("R3 pwr_state vs model", int'(pwr_state), exp_pwr(m_en));
            check("R3 dac_on vs model", int'(dac_on), int'(m_en[0]));
            check("R11 dac_ready vs model", int'(dac_ready), int'(m_en[0] && m_wait == 0));
            check("R12 cont_mode vs model", int'(cont_mode), int'(m_cont));
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_stb = 1'b1;
        bit_in  = b;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        @(negedge clk);
        bit_stb = 1'b0;
        bit_in  = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_stb = 1'b0;
        end
    endtask

    task automatic set_cs(input logic v);
        @(negedge clk);
        bit_stb = 1'b0;
        cs_n = v;
    endtask

    initial begin
        #200000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        total = 0; bad = 0; done = 0;
        rst = 1'b1; cs_n = 1'b1; bit_stb = 1'b0; bit_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset code", int'(dac_code), 0);
        check("R1 reset power", int'(pwr_state), 0);
        check("R1 reset ready", int'(dac_ready), 0);

        // R2: leading zeros then DAC-addressed word, ref+dac on, single
        set_cs(1'b0);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        send_byte(8'b1100_0101);
        check("R2 R3 DAC only state", int'(pwr_state), 3);
        check("R11 not ready right after enable", int'(dac_ready), 0);
        send_byte(8'hA5);
        check("R4 code loaded", int'(dac_code), 8'hA5);
        idle(WK);
        check("R11 ready after wake", int'(dac_ready), 1);

        // R6: single mode, trailing zeros ignored
        send_byte(8'h00);
        send_byte(8'h00);
        check("R6 code unchanged", int'(dac_code), 8'hA5);

        // R5: load while disabled, apply on enable
        send_byte(8'b1100_0100);
        check("R3 standby state", int'(pwr_state), 1);
        check("R11 ready low when off", int'(dac_ready), 0);
        send_byte(8'h5A);
        check("R5 code held while off", int'(dac_code), 8'hA5);
        send_byte(8'b1000_0101);
        check("R5 held byte applied", int'(dac_code), 8'h5A);

        // R7: continuous streaming
        send_byte(8'b1100_1111);
        check("R3 both state", int'(pwr_state), 4);
        check("R12 continuous mode set", int'(cont_mode), 1);
        send_byte(8'h11);
        check("R7 byte one", int'(dac_code), 8'h11);
        send_byte(8'h22);
        check("R7 byte two", int'(dac_code), 8'h22);
        send_byte(8'h33);
        check("R7 byte three", int'(dac_code), 8'h33);

        // R8: select high ignores strobes and ends continuous mode
        set_cs(1'b1);
        send_byte(8'hFF);
        check("R8 ignored while deselected", int'(dac_code), 8'h33);
        check("R8 mode cleared", int'(cont_mode), 0);
        set_cs(1'b0);
        send_byte(8'h00);
        check("R8 new control needed", int'(dac_code), 8'h33);

        // R9: partial data byte discarded
        send_byte(8'b1100_0111);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        set_cs(1'b1);
        idle(1);
        check("R9 partial discarded", int'(dac_code), 8'h33);
        check("R9 enables kept", int'(pwr_state), 4);
        set_cs(1'b0);

        // R10: abort inside control word
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        set_cs(1'b1);
        idle(1);
        check("R10 full shutdown", int'(pwr_state), 0);
        check("R10 dac off", int'(dac_on), 0);
        check("R10 code kept", int'(dac_code), 8'h33);
        set_cs(1'b0);

        // R3 other patterns, R11 restart and no-restart
        send_byte(8'b1010_0110);
        check("R3 ADC only state", int'(pwr_state), 2);
        send_byte(8'b1000_0011);
        check("R3 no-reference state", int'(pwr_state), 5);
        check("R11 restart after shutdown", int'(dac_ready), 0);
        idle(WK - 1);
        check("R11 one cycle before expiry", int'(dac_ready), 0);
        idle(1);
        check("R11 ready at expiry", int'(dac_ready), 1);
        send_byte(8'b1000_0001);
        check("R11 re-enable keeps ready", int'(dac_ready), 1);
        idle(4);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule